// File: doc/BRIEF.md
# Per-Pin Input Interrupt Detector

This block watches a bank of general-purpose input pins and raises one interrupt when any enabled pin meets its trigger condition. Every pin is first brought into the local clock domain through a multi-stage synchronizer. It is then compared against its own value from the previous cycle, so that edges can be found.

Three per-bit mode registers choose the trigger for each pin. The dual-edge bit takes precedence over everything else. Otherwise the level-select bit chooses between level sensing and single-edge sensing, and the polarity bit chooses high or rising when set, and low or falling when clear.

A hit sets a sticky pending bit, and software clears that bit by writing a one to it. The block's single interrupt line is a registered OR of all pending bits whose enable bit is set. Software reaches all the registers through a small word-addressed write/read port, and reads return data combinationally.

Top module: `pin_irq_bank`

## Requirements
- R1: After reset, every register (enable, polarity, level-select, dual-edge, pending) reads zero and `irqOut` is low.
- R2: A write with `wrEn` high stores `wrData` in the addressed register, and a read returns it. The byte offsets are: enable 0x00, polarity 0x04, level-select 0x08, dual-edge 0x0C, pending 0x10. Any other address reads zero.
- R3: When a pin's dual-edge bit is 0 and its level-select bit is 0, polarity 1 sets the pending bit on a rising edge only, and polarity 0 sets it on a falling edge only.
- R4: When a pin's dual-edge bit is 1, both rising and falling edges set its pending bit, whatever its level-select and polarity bits hold.
- R5: When a pin's dual-edge bit is 0 and its level-select bit is 1, the pending bit is set on every cycle in which the synchronized pin equals its polarity bit (1 means high, 0 means low). A clear issued while the level is still active therefore leaves the bit set. After the level goes away the bit stays set until it is cleared.
- R6: Writing to the pending register clears exactly the bits written as 1. Bits written as 0 keep their value, and writing all ones clears every bit.
- R7: `irqOut` is a registered OR over the bitwise AND of pending and enable. It follows a change of enable one clock later, and it stays low while enable is all zeros.
- R8: If a trigger hit and a clear of the same bit fall in the same cycle, the pending bit stays set.
- R9: An input change becomes visible in the pending register at the third rising clock edge after it is applied, and is not visible at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | NUM_PINS | Asynchronous input pins |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wrData | input | NUM_PINS | Write data |
| rdData | output | NUM_PINS | Combinational read data for `addr` |
| irqOut | output | 1 | Aggregate interrupt, registered |

## Verification
A trigger hit can land in the same cycle as a software clear of the same pending bit, and the bench forces that collision on purpose. For an edge, it drops a dual-edge pin and then issues the clear exactly two clock edges later, which is the cycle the synchronized edge is seen. For a level, it clears while the level is still held. In both cases the bench judges the result by reading the pending register back afterwards and expecting the bit still set. A second clear with no hit present then confirms that clearing itself works.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic [2:0] {
    SEL_ENABLE   = 3'd0,
    SEL_POLARITY = 3'd1,
    SEL_LEVEL    = 3'd2,
    SEL_BOTH     = 3'd3,
    SEL_PENDING  = 3'd4,
    SEL_NONE     = 3'd7
  } regSelE;

  typedef struct packed {
    logic   wrEnable;
    logic   wrPolarity;
    logic   wrLevel;
    logic   wrBoth;
    logic   wrClear;
    regSelE rdSel;
  } ctrlStrobeT;

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobeT        strobe
);

  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] wordIdx;
  regSelE           sel;

  assign aligned = (addr[1:0] == 2'b00);
  assign wordIdx = addr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      case (wordIdx)
        IDX_W'(0): sel = SEL_ENABLE;
        IDX_W'(1): sel = SEL_POLARITY;
        IDX_W'(2): sel = SEL_LEVEL;
        IDX_W'(3): sel = SEL_BOTH;
        IDX_W'(4): sel = SEL_PENDING;
        default:   sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.rdSel      = sel;
    strobe.wrEnable   = wrEn && (sel == SEL_ENABLE);
    strobe.wrPolarity = wrEn && (sel == SEL_POLARITY);
    strobe.wrLevel    = wrEn && (sel == SEL_LEVEL);
    strobe.wrBoth     = wrEn && (sel == SEL_BOTH);
    strobe.wrClear    = wrEn && (sel == SEL_PENDING);
  end

endmodule

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinSync,
  input  ctrlStrobeT          strobe,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] enableQ, polarityQ, levelQ, bothQ, pendingQ, prevQ;
  logic [NUM_PINS-1:0] eventVec, levelHit, clearMask;
  logic                irqQ;

  // per-pin trigger selection: dual-edge wins, then level, then single edge
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall, match;
    assign rise  = pinSync[i] & ~prevQ[i];
    assign fall  = ~pinSync[i] & prevQ[i];
    assign match = (pinSync[i] == polarityQ[i]);
    assign levelHit[i] = ~bothQ[i] & levelQ[i] & match;
    always_comb begin
      if (bothQ[i])       eventVec[i] = rise | fall;
      else if (levelQ[i]) eventVec[i] = match;
      else                eventVec[i] = polarityQ[i] ? rise : fall;
    end
  end

  assign clearMask = strobe.wrClear ? wrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ   <= '0;
      polarityQ <= '0;
      levelQ    <= '0;
      bothQ     <= '0;
      pendingQ  <= '0;
      prevQ     <= '0;
      irqQ      <= 1'b0;
    end else begin
      if (strobe.wrEnable)   enableQ   <= wrData;
      if (strobe.wrPolarity) polarityQ <= wrData;
      if (strobe.wrLevel)    levelQ    <= wrData;
      if (strobe.wrBoth)     bothQ     <= wrData;
      pendingQ <= (pendingQ & ~clearMask) | eventVec;
      prevQ    <= pinSync;
      irqQ     <= |(pendingQ & enableQ);
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_ENABLE:   rdData = enableQ;
      SEL_POLARITY: rdData = polarityQ;
      SEL_LEVEL:    rdData = levelQ;
      SEL_BOTH:     rdData = bothQ;
      SEL_PENDING:  rdData = pendingQ;
      default:      rdData = '0;
    endcase
  end

  assign irqOut = irqQ;

  // R6
  clear_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrClear |=> ((pendingQ & $past(pendingQ)) == $past(pendingQ)));

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventVec != '0) |=> ((pendingQ & $past(eventVec)) == $past(eventVec)));

  // R5
  level_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelHit != '0) |=> ((pendingQ & $past(levelHit)) == $past(levelHit)));

  // R7
  mask_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == '0) |=> !irqOut);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(pendingQ & enableQ) != '0));

endmodule

// File: rtl/pin_irq_bank.sv
module pin_irq_bank
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] pinSync;
  ctrlStrobeT          strobe;

  pin_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .din(pinIn), .dout(pinSync)
  );

  pin_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .wrEn(wrEn), .addr(addr), .strobe(strobe)
  );

  pin_irq_datapath #(.NUM_PINS(NUM_PINS)) dp_i (
    .clk(clk), .rstN(rstN), .pinSync(pinSync), .strobe(strobe),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

endmodule

// File: tb/pin_irq_bank_tb_top.sv
`timescale 1ns/1ps
module pin_irq_bank_tb_top;

  localparam logic [4:0] A_EN = 5'h00, A_POL = 5'h04, A_LVL = 5'h08,
                         A_BOTH = 5'h0C, A_PEND = 5'h10;

  // {dual, level, polarity}_{pin}_{start, end}_{expA, expB}
  localparam logic [11:0] VEC [10] = '{
    12'b001_00000_01_01, 12'b001_00001_10_00,
    12'b000_00010_10_01, 12'b000_00011_01_00,
    12'b100_00100_01_01, 12'b111_00101_10_01,
    12'b011_00110_01_01, 12'b011_00111_10_11,
    12'b010_11111_10_01, 12'b010_11110_01_11
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinIn = '0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;
  int          checks = 0;
  int          fails = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  pin_irq_bank dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(input logic [31:0] b, input logic [31:0] l, input logic [31:0] p);
    regWrite(A_BOTH, b);
    regWrite(A_LVL, l);
    regWrite(A_POL, p);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    // R1 reset state
    regRead(A_EN, rd);   check("R1 enable", rd, 0);
    regRead(A_POL, rd);  check("R1 polarity", rd, 0);
    regRead(A_LVL, rd);  check("R1 level", rd, 0);
    regRead(A_BOTH, rd); check("R1 dual", rd, 0);
    regRead(A_PEND, rd); check("R1 pending", rd, 0);
    check("R1 irq", {31'b0, irqOut}, 0);

    // R2 readback
    regWrite(A_EN, 32'hA5A5_5A5A);   regRead(A_EN, rd);   check("R2 enable", rd, 32'hA5A5_5A5A);
    regWrite(A_POL, 32'h1234_5678);  regRead(A_POL, rd);  check("R2 polarity", rd, 32'h1234_5678);
    regWrite(A_LVL, 32'h0F0F_00FF);  regRead(A_LVL, rd);  check("R2 level", rd, 32'h0F0F_00FF);
    regWrite(A_BOTH, 32'hFFFF_0000); regRead(A_BOTH, rd); check("R2 dual", rd, 32'hFFFF_0000);
    regRead(5'h14, rd); check("R2 unmapped", rd, 0);
    regWrite(A_EN, 0);
    configure(0, 0, 0);
    regWrite(A_PEND, '1);

    // vector table: R3 / R4 / R5
    for (int i = 0; i < 10; i++) begin
      logic [11:0] v;
      int p;
      string tag;
      v = VEC[i];
      p = int'(v[8:4]);
      tag = v[11] ? "R4" : (v[10] ? "R5" : "R3");
      configure(32'(v[11]) << p, 32'(v[10]) << p, 32'(v[9]) << p);
      pinIn[p] = v[3];
      waitCycles(5);
      regWrite(A_PEND, '1);
      regRead(A_PEND, rd);
      check($sformatf("%s vec%0d start", tag, i), {31'b0, rd[p]}, {31'b0, v[1]});
      pinIn[p] = v[2];
      waitCycles(5);
      regRead(A_PEND, rd);
      check($sformatf("%s vec%0d end", tag, i), {31'b0, rd[p]}, {31'b0, v[0]});
    end

    // R9 latency through synchronizer
    configure(0, 0, 32'h0000_0100);
    regWrite(A_PEND, '1);
    addr = A_PEND;
    pinIn[8] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9 not yet", {31'b0, rdData[8]}, 0);
    @(posedge clk); @(negedge clk);
    check("R9 visible", {31'b0, rdData[8]}, 1);

    // R6 selective clear
    configure(0, 0, 32'h0000_0700);
    regWrite(A_PEND, '1);
    pinIn[9] = 1'b1; pinIn[10] = 1'b1;
    waitCycles(5);
    regRead(A_PEND, rd); check("R6 both set", rd, 32'h0000_0600);
    regWrite(A_PEND, 32'h0000_0200);
    regRead(A_PEND, rd); check("R6 one cleared", rd, 32'h0000_0400);
    regWrite(A_PEND, 0);
    regRead(A_PEND, rd); check("R6 zero write", rd, 32'h0000_0400);

    // R7 enable masking and registered irq
    waitCycles(1);
    check("R7 disabled", {31'b0, irqOut}, 0);
    regWrite(A_EN, 32'h0000_0200);
    waitCycles(1);
    check("R7 other bit enabled", {31'b0, irqOut}, 0);
    regWrite(A_EN, 32'h0000_0400);
    check("R7 one-cycle lag", {31'b0, irqOut}, 0);
    waitCycles(1);
    check("R7 asserted", {31'b0, irqOut}, 1);
    regWrite(A_EN, '1);
    waitCycles(1);
    check("R7 all enabled", {31'b0, irqOut}, 1);
    regWrite(A_EN, 0);
    waitCycles(1);
    check("R7 all masked", {31'b0, irqOut}, 0);

    // R8 edge coinciding with clear
    configure(32'h0000_0800, 0, 0);
    regWrite(A_PEND, '1);
    pinIn[11] = 1'b1;
    waitCycles(5);
    regRead(A_PEND, rd); check("R4 dual rise", rd, 32'h0000_0800);
    pinIn[11] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    regWrite(A_PEND, 32'h0000_0800);
    regRead(A_PEND, rd); check("R8 edge wins", rd, 32'h0000_0800);
    regWrite(A_PEND, 32'h0000_0800);
    regRead(A_PEND, rd); check("R8 later clear", rd, 0);

    // R5 level clear while active, then after release
    configure(0, 32'h0000_1000, 32'h0000_1000);
    pinIn[12] = 1'b1;
    waitCycles(5);
    regWrite(A_PEND, '1);
    regRead(A_PEND, rd); check("R5 reasserts", rd, 32'h0000_1000);
    pinIn[12] = 1'b0;
    waitCycles(5);
    regRead(A_PEND, rd); check("R5 sticky", rd, 32'h0000_1000);
    regWrite(A_PEND, '1);
    regRead(A_PEND, rd); check("R5 cleared", rd, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule